// File: doc/BRIEF.md
# BCD Clock-Register to Elapsed-Seconds Converter

This block turns the time-of-day and day digits held in a clock chip's nibble-wide registers into one binary count of seconds. It sits in front of a register read port, such as a serial master that talks to the clock chip. A single-cycle pulse on `start` launches a conversion. The block then reads eight digit registers one at a time: units and tens of seconds, units and tens of minutes, units and tens of hours, and units and tens of day. Each digit is multiplied by its weight in seconds and added to a running sum. When the last digit has been added, the 32-bit total is presented with a one-cycle valid pulse.

The read port is split into a request stream (`req_valid`/`req_ready` with the register address) and a response stream (`rsp_valid`/`rsp_ready` with the read data). A request transfers on a cycle where both its valid and its ready are high. Once `req_valid` rises, it stays high with a stable address until `req_ready` is seen. The block issues a new request only after the response to the previous one has been accepted. `rsp_ready` is high only while a response is awaited, and response data offered at any other time is ignored. The register address of each digit is a parameter, so the digit-to-address map can follow whatever chip sits behind the port. Month and year take no part in the result.

Top module: `bcd_time_to_secs`

## Requirements
- R1: After reset, `req_valid`, `rsp_ready` and `secs_valid` are 0 and `secs` is 0.
- R2: A `start` pulse while idle begins a conversion whose requests address, in this order, the seconds-units, seconds-tens, minutes-units, minutes-tens, hours-units, hours-tens, day-units and day-tens registers, using the addresses given by the parameters `ADDR_SEC_U` … `ADDR_DAY_T`.
- R3: Once `req_valid` is high it stays high, with `req_addr` unchanged, until a cycle where `req_ready` is also high.
- R4: At most one read is outstanding. After a request transfers, `rsp_ready` is high from the next cycle until a response transfers. `req_valid` is low while `rsp_ready` is high, and the next request is raised in the cycle after a response transfer. A response offered while `rsp_ready` is low has no effect.
- R5: Only bits [3:0] of `rsp_data` are used, and the upper bits never change the result.
- R6: The result is S + 60·M + 3600·H + 86400·D. Here S, M, H and D are each the units digit plus ten times the tens digit of their field.
- R7: `secs_valid` is high for exactly one cycle, the cycle after the day-tens response transfers. `secs` carries the new result from that cycle on and holds it until the next conversion completes.
- R8: A `start` pulse that arrives while a conversion is in progress is ignored. The conversion continues unchanged and only one result is produced.
- R9: A nibble above 9 is not rejected. Its binary value (10 to 15) is weighted like any other digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion start pulse, honoured only while idle |
| req_valid | output | 1 | Register read request valid |
| req_ready | input | 1 | Read port accepts the request |
| req_addr | output | ADDR_W (4) | Address of the digit register being read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Block is waiting for read data |
| rsp_data | input | RSP_W (8) | Read data, low nibble holds the digit |
| secs_valid | output | 1 | One-cycle pulse marking a fresh result |
| secs | output | RES_W (32) | Elapsed seconds, unsigned |

## Verification
A wrong digit index shows up directly at `req_addr`. It appears on the very request that follows the fault, because the address of every request is compared against the expected digit order. A wrong accumulator term, a dropped upper-bit mask or a missing clear stays hidden until the `secs_valid` pulse, which can be up to eight handshakes later. At that point `secs` disagrees with the weighted sum of the register contents. A corrupted sequencer state, such as an accepted start while busy or an extra request, shows up within one cycle as `req_valid` or `rsp_ready` differing from the bench's model of the handshake phase.

// File: rtl/bcdsec_pkg.sv
package bcdsec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } seq_state_e;

  // two digits (units, tens) for each of seconds, minutes, hours, day
  localparam int FIELDS     = 4;
  localparam int FIELD_DIGS = 2;
  localparam int DIGITS     = FIELDS * FIELD_DIGS;

  // seconds carried by one count of digit idx (even = units, odd = tens)
  function automatic logic [31:0] digit_weight(input int unsigned idx);
    logic [31:0] w;
    case (idx / FIELD_DIGS)
      0:       w = 32'd1;
      1:       w = 32'd60;
      2:       w = 32'd3600;
      default: w = 32'd86400;
    endcase
    if ((idx % FIELD_DIGS) != 0) w = w * 32'd10;
    return w;
  endfunction

endpackage

// File: rtl/bcdsec_seq.sv
module bcdsec_seq
  import bcdsec_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             req_valid,
  output logic             rsp_ready,
  output logic [IDX_W-1:0] idx,
  output logic             clear,
  output logic             take,
  output logic             take_last,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_RSP);
  assign clear     = (state_q == ST_IDLE) && start;
  assign take      = rsp_ready && rsp_valid;
  assign take_last = take && (idx_q == LAST_IDX);
  assign idx       = idx_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take_last;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_REQ;
            idx_q   <= '0;
          end
        end
        ST_REQ: begin
          if (req_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
              idx_q   <= idx_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a transferred request is followed by a wait for its response
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_ready && !req_valid));

  // R4: a non-final response transfer raises the next request at once
  p_next_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_last) |=> req_valid);

  // R7: result pulse is one cycle wide
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: start during a wait leaves the digit position alone
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rsp_ready && !rsp_valid) |=> (rsp_ready && $stable(idx)));

endmodule

// File: rtl/bcdsec_addr_map.sv
module bcdsec_addr_map #(
  parameter int                            NUM_DIGITS = 8,
  parameter int                            ADDR_W     = 4,
  parameter int                            IDX_W      = $clog2(NUM_DIGITS),
  parameter logic [NUM_DIGITS*ADDR_W-1:0]  ADDR_TABLE = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] slot [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
    assign slot[g] = ADDR_TABLE[g*ADDR_W +: ADDR_W];
  end

  assign addr = slot[idx];

endmodule

// File: rtl/bcdsec_accum.sv
module bcdsec_accum
  import bcdsec_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS),
  parameter int RES_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             last,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       nibble,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] wtab [NUM_DIGITS];
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] result_q;
  logic [RES_W-1:0] term;
  logic [RES_W-1:0] sum;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_weight
    assign wtab[g] = RES_W'(digit_weight(g));
  end

  assign term   = RES_W'(nibble) * wtab[idx];
  assign sum    = acc_q + term;
  assign result = result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      if (clear)     acc_q <= '0;
      else if (take) acc_q <= sum;
      if (take && last) result_q <= sum;
    end
  end

  // R6: a new conversion starts from an empty sum
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0));

  // R7: result only moves on the final digit
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && last) |=> $stable(result));

endmodule

// File: rtl/bcd_time_to_secs.sv
module bcd_time_to_secs
  import bcdsec_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                RSP_W      = 8,
  parameter int                RES_W      = 32,
  parameter logic [ADDR_W-1:0] ADDR_SEC_U = 4'h0,
  parameter logic [ADDR_W-1:0] ADDR_SEC_T = 4'h1,
  parameter logic [ADDR_W-1:0] ADDR_MIN_U = 4'h2,
  parameter logic [ADDR_W-1:0] ADDR_MIN_T = 4'h3,
  parameter logic [ADDR_W-1:0] ADDR_HR_U  = 4'h4,
  parameter logic [ADDR_W-1:0] ADDR_HR_T  = 4'h5,
  parameter logic [ADDR_W-1:0] ADDR_DAY_U = 4'h6,
  parameter logic [ADDR_W-1:0] ADDR_DAY_T = 4'h7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [RSP_W-1:0]  rsp_data,
  output logic              secs_valid,
  output logic [RES_W-1:0]  secs
);

  localparam int NUM_DIGITS = DIGITS;
  localparam int IDX_W      = $clog2(NUM_DIGITS);
  localparam logic [NUM_DIGITS*ADDR_W-1:0] ADDR_TABLE = {
    ADDR_DAY_T, ADDR_DAY_U, ADDR_HR_T, ADDR_HR_U,
    ADDR_MIN_T, ADDR_MIN_U, ADDR_SEC_T, ADDR_SEC_U
  };

  logic [IDX_W-1:0] idx;
  logic             clear;
  logic             take;
  logic             take_last;
  logic [3:0]       nibble;
  logic             unused_rsp_hi;

  assign nibble        = rsp_data[3:0];
  assign unused_rsp_hi = ^rsp_data[RSP_W-1:4];

  bcdsec_seq #(
    .NUM_DIGITS (NUM_DIGITS),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .idx       (idx),
    .clear     (clear),
    .take      (take),
    .take_last (take_last),
    .done      (secs_valid)
  );

  bcdsec_addr_map #(
    .NUM_DIGITS (NUM_DIGITS),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .ADDR_TABLE (ADDR_TABLE)
  ) u_map (
    .idx  (idx),
    .addr (req_addr)
  );

  bcdsec_accum #(
    .NUM_DIGITS (NUM_DIGITS),
    .IDX_W      (IDX_W),
    .RES_W      (RES_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .take   (take),
    .last   (take_last),
    .idx    (idx),
    .nibble (nibble),
    .result (secs)
  );

  // R3: a stalled request keeps its valid and its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R4: request and response phases never overlap
  p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

endmodule

// File: tb/bcd_time_to_secs_test.sv
module bcd_time_to_secs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [7:0]  rsp_data;
  logic        secs_valid;
  logic [31:0] secs;

  always #10 clk = ~clk;   // 50 MHz

  bcd_time_to_secs #(
    .ADDR_SEC_U (4'h9), .ADDR_SEC_T (4'h3),
    .ADDR_MIN_U (4'hC), .ADDR_MIN_T (4'h5),
    .ADDR_HR_U  (4'h1), .ADDR_HR_T  (4'hE),
    .ADDR_DAY_U (4'h6), .ADDR_DAY_T (4'hA)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .secs_valid(secs_valid), .secs(secs)
  );

  int amap [8] = '{9, 3, 12, 5, 1, 14, 6, 10};
  int wt   [8] = '{1, 10, 60, 600, 3600, 36000, 86400, 864000};
  int rtc  [16];

  int n_tests = 0;
  int n_fail  = 0;

  int stall_mode = 0;
  int busy_start = 0;
  int go_cnt = 0, go_seen = 0, done_cnt = 0, runs = 0;

  // reference model state
  int      m_phase;     // 0 idle, 1 request, 2 response
  int      m_idx;
  longint  m_acc;
  longint  m_result;
  bit      m_pulse;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint formula();
    longint s, m, h, d;
    s = rtc[amap[0]] + 10 * rtc[amap[1]];
    m = rtc[amap[2]] + 10 * rtc[amap[3]];
    h = rtc[amap[4]] + 10 * rtc[amap[5]];
    d = rtc[amap[6]] + 10 * rtc[amap[7]];
    return s + 60 * m + 3600 * h + 86400 * d;
  endfunction

  always @(negedge clk) begin
    logic        st, rdy, rv;
    logic [7:0]  rd;
    if (!rst_n) begin
      start = 0; req_ready = 0; rsp_valid = 0; rsp_data = 0;
      m_phase = 0; m_idx = 0; m_acc = 0; m_result = 0; m_pulse = 0;
    end else begin
      // compare against the model
      chk(req_valid == (m_phase == 1), "R3 req_valid", req_valid, m_phase == 1);
      chk(rsp_ready == (m_phase == 2), "R4 rsp_ready", rsp_ready, m_phase == 2);
      if (m_phase == 1)
        chk(req_addr == amap[m_idx], "R2 req_addr", req_addr, amap[m_idx]);
      chk(secs_valid == m_pulse, "R7 secs_valid", secs_valid, m_pulse);
      chk(secs == m_result, "R6 secs", secs, m_result);
      if (m_pulse) begin
        chk(secs == formula(), "R6 weighted sum", secs, formula());
        done_cnt++;
      end
      // drive inputs
      st = 0;
      if (m_phase == 0 && go_seen != go_cnt) begin
        st = 1; go_seen = go_cnt;
      end else if (busy_start != 0 && m_phase != 0 && $urandom_range(0, 2) == 0) begin
        st = 1;   // R8 stimulus
      end
      rdy = (stall_mode != 0) ? ($urandom_range(0, 3) != 0) : 1'b1;
      rv = 0; rd = 8'($urandom_range(0, 255));
      if (m_phase == 2) begin
        rv = (stall_mode != 0) ? ($urandom_range(0, 2) != 0) : 1'b1;
        rd = {4'($urandom_range(0, 15)), 4'(rtc[amap[m_idx]])};  // R5 garbage high bits
      end else if (stall_mode != 0) begin
        rv = ($urandom_range(0, 1) != 0);                         // R4 ignored offer
      end
      start = st; req_ready = rdy; rsp_valid = rv; rsp_data = rd;
      // advance model
      m_pulse = 0;
      case (m_phase)
        0: if (st) begin m_phase = 1; m_idx = 0; m_acc = 0; end
        1: if (rdy) m_phase = 2;
        default: if (rv) begin
          m_acc = m_acc + longint'(rd & 8'h0F) * wt[m_idx];
          if (m_idx == 7) begin
            m_result = m_acc; m_pulse = 1; m_phase = 0;
          end else begin
            m_idx++; m_phase = 1;
          end
        end
      endcase
    end
  end

  task automatic set_digits(input int su, st, mu, mt, hu, ht, du, dt);
    int v [8];
    v = '{su, st, mu, mt, hu, ht, du, dt};
    foreach (v[k]) rtc[amap[k]] = v[k];
  endtask

  task automatic run(input longint expect_val, input string tag);
    int d;
    d = done_cnt;
    go_cnt++;
    runs++;
    wait (done_cnt != d);
    @(negedge clk);
    chk(secs == expect_val, tag, secs, expect_val);
    repeat (3) @(negedge clk);
    chk(secs == expect_val, "R7 result held", secs, expect_val);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rtc[i] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(req_valid == 0, "R1 req_valid reset", req_valid, 0);
    chk(rsp_ready == 0, "R1 rsp_ready reset", rsp_ready, 0);
    chk(secs_valid == 0, "R1 secs_valid reset", secs_valid, 0);
    chk(secs == 0, "R1 secs reset", secs, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    set_digits(0, 0, 0, 0, 0, 0, 0, 0);
    run(0, "R6 all zero");

    stall_mode = 1;
    set_digits(9, 5, 9, 5, 3, 2, 9, 9);
    run(8639999, "R6 max time");

    set_digits(7, 3, 4, 1, 8, 0, 5, 1);
    busy_start = 1;
    run(1325677, "R8 start while busy");
    stall_mode = 0;
    run(1325677, "R8 start while busy, no stall");
    busy_start = 0;

    stall_mode = 1;
    set_digits(15, 15, 15, 15, 15, 15, 15, 15);
    run(14860065, "R9 nibbles above nine");

    set_digits(12, 0, 0, 10, 0, 0, 11, 0);
    run(12 + 60 * 100 + 86400 * 11, "R9 mixed non-BCD");

    for (int r = 0; r < 20; r++) begin
      stall_mode = r % 2;
      busy_start = (r % 3 == 0) ? 1 : 0;
      set_digits($urandom_range(0, 9), $urandom_range(0, 5), $urandom_range(0, 9),
                 $urandom_range(0, 5), $urandom_range(0, 9), $urandom_range(0, 2),
                 $urandom_range(0, 9), $urandom_range(0, 9));
      run(formula(), "R6 random digits");
    end
    busy_start = 0;
    repeat (5) @(negedge clk);
    chk(done_cnt == runs, "R8 one result per start", done_cnt, runs);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d results expected %0d", done_cnt, runs);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule